// File: doc/BRIEF.md
# Trimmed One-Second Prescaler

This block turns a one-cycle enable, pulsed once per cycle of a 32,768 Hz crystal oscillator, into a one-second tick. Each second is built from a coarse stage of 2^LO_BITS oscillator cycles, counted HI_COUNT times. Crystal error is corrected digitally, without trim capacitors. Inside a repeating 64-minute cycle, the first second of some minutes is made shorter or longer at the coarse stage. A 5-bit magnitude selects how many minutes are affected, and a sign bit selects the direction.

The block also drives one test pin. In frequency-test mode the pin shows a square wave taken straight from the raw oscillator count, so the trim setting has no effect on it. In the other mode the pin holds a static level chosen by software. A halt input freezes the oscillator side of the block, and every counter then keeps its value. Counting of minutes, hours and dates is left to the next stage. This block only keeps the second-in-minute and minute-in-cycle positions that the trim schedule needs.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: With no trim applied to a second, that second lasts HI_COUNT x 2^LO_BITS enabled oscillator cycles (32,768 with the defaults).
- R2: `sec_tick` is a single-clock pulse. It rises only in the clock after an edge where `osc_en` was 1 and `halt` was 0.
- R3: With `cal_sign` = 1, a trimmed second is shortened by exactly 2^LO_BITS oscillator cycles (256 with the defaults).
- R4: With `cal_sign` = 0, a trimmed second is lengthened by exactly 2^(LO_BITS-1) oscillator cycles (128 with the defaults).
- R5: Only the first second (index 0) of a minute is trimmed, and only in minutes 0 to 2N-1 of the 64-minute cycle, where N = `cal_mag`. N = 0 trims nothing, and N = 31 trims minutes 0 to 61.
- R6: The minute position wraps from 63 back to 0, so the trim pattern repeats every 64 minutes.
- R7: With `ftest_en` = 1, `ftest_pin` toggles once every 2^FT_BITS enabled oscillator cycles, starting from 0. This gives 512 Hz from 32,768 Hz with the defaults, for any trim value.
- R8: With `ftest_en` = 0, `ftest_pin` equals `out_level`.
- R9: While `halt` is 1, or while `osc_en` is 0, the second divider, the second and minute positions, and the test divider all hold. No tick is issued, and after release the count of the current second carries on from where it stopped.
- R10: During reset `sec_tick` is 0 and the test toggle is 0, so `ftest_pin` shows 0 in test mode and `out_level` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_en | input | 1 | One-clock enable per oscillator cycle |
| halt | input | 1 | Freeze all oscillator-driven state |
| cal_mag | input | CAL_BITS | Trim magnitude N |
| cal_sign | input | 1 | Trim direction: 1 shortens (faster), 0 lengthens (slower) |
| ftest_en | input | 1 | Select the frequency-test square wave on the pin |
| out_level | input | 1 | Static pin level when test mode is off |
| sec_tick | output | 1 | One-clock pulse at the end of each second |
| ftest_pin | output | 1 | Test square wave or static level |

## Verification
Two events can land on the same oscillator edge: the end of a trimmed second and a toggle of the test output. A 4-cycle toggle period against seconds of 12, 16 and 18 cycles makes them coincide often. The toggle interval must still measure exactly 4 while every second length is checked. A second pair falls together at each 64-minute wrap: the minute position wraps back to zero and the schedule has to re-arm the trim of the next second. Sweeps therefore run six seconds past the wrap, and the length of second 192 (trimmed again) is judged arithmetically from its index.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  typedef enum logic [1:0] {
    TRIM_NONE  = 2'd0,
    TRIM_SHORT = 2'd1,
    TRIM_LONG  = 2'd2
  } trim_e;
endpackage

// File: rtl/trim_divider.sv
module trim_divider
  import rtc_trim_pkg::*;
#(
  parameter int LO_BITS  = 8,
  parameter int HI_COUNT = 128
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  trim_e mode,
  output logic  sec_end
);
  localparam int LO_W   = LO_BITS + 1;
  localparam int HI_W   = (HI_COUNT > 1) ? $clog2(HI_COUNT) : 1;
  localparam int LO_PER = 1 << LO_BITS;

  logic [LO_W-1:0] lo_q, lo_d, lo_last;
  logic [HI_W-1:0] hi_q, hi_d, hi_last;
  logic            stage_end, at_end;

  always_comb begin
    hi_last   = (mode == TRIM_SHORT) ? HI_W'(HI_COUNT - 2) : HI_W'(HI_COUNT - 1);
    lo_last   = (mode == TRIM_LONG && hi_q == hi_last) ?
                LO_W'(LO_PER + LO_PER / 2 - 1) : LO_W'(LO_PER - 1);
    stage_end = (lo_q == lo_last);
    at_end    = stage_end && (hi_q == hi_last);
    lo_d      = lo_q;
    hi_d      = hi_q;
    if (adv) begin
      if (stage_end) begin
        lo_d = '0;
        hi_d = at_end ? '0 : hi_q + HI_W'(1);
      end else begin
        lo_d = lo_q + LO_W'(1);
      end
    end
  end

  assign sec_end = adv && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(lo_q) && $stable(hi_q))); // R9
endmodule

// File: rtl/trim_schedule.sv
module trim_schedule
  import rtc_trim_pkg::*;
#(
  parameter int SEC_PER_MIN = 60,
  parameter int CAL_BITS    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sec_end,
  input  logic [CAL_BITS-1:0] cal_mag,
  input  logic                cal_sign,
  output trim_e               mode
);
  localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam int CYC_W = CAL_BITS + 1;

  logic [SEC_W-1:0] sec_q, sec_d;
  logic [CYC_W-1:0] min_q, min_d;
  logic [CYC_W-1:0] trim_span;

  always_comb begin
    trim_span = {cal_mag, 1'b0};
    sec_d     = sec_q;
    min_d     = min_q;
    if (sec_end) begin
      if (sec_q == SEC_W'(SEC_PER_MIN - 1)) begin
        sec_d = '0;
        min_d = min_q + CYC_W'(1);
      end else begin
        sec_d = sec_q + SEC_W'(1);
      end
    end
    if (sec_q == '0 && min_q < trim_span)
      mode = cal_sign ? TRIM_SHORT : TRIM_LONG;
    else
      mode = TRIM_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      min_q <= '0;
    end else begin
      sec_q <= sec_d;
      min_q <= min_d;
    end
  end

  AST_MIN_STEPS_ON_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (min_q != $past(min_q)) |-> $past(sec_end)); // R6
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_end |=> ($stable(sec_q) && $stable(min_q))); // R9
endmodule

// File: rtl/ftest_out.sv
module ftest_out #(
  parameter int FT_BITS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic ftest_en,
  input  logic out_level,
  output logic pin
);
  logic [FT_BITS-1:0] cnt_q, cnt_d;
  logic               tog_q, tog_d;

  always_comb begin
    cnt_d = cnt_q;
    tog_d = tog_q;
    if (adv) begin
      cnt_d = cnt_q + FT_BITS'(1);
      if (&cnt_q) tog_d = ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tog_q <= tog_d;
    end
  end

  assign pin = ftest_en ? tog_q : out_level;

  AST_FT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(tog_q)); // R9
endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
  import rtc_trim_pkg::*;
#(
  parameter int LO_BITS     = 8,
  parameter int HI_COUNT    = 128,
  parameter int SEC_PER_MIN = 60,
  parameter int CAL_BITS    = 5,
  parameter int FT_BITS     = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                osc_en,
  input  logic                halt,
  input  logic [CAL_BITS-1:0] cal_mag,
  input  logic                cal_sign,
  input  logic                ftest_en,
  input  logic                out_level,
  output logic                sec_tick,
  output logic                ftest_pin
);
  logic  rst_meta, rst_sync_n;
  logic  adv, sec_end, tick_d;
  trim_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign adv    = osc_en && !halt;
  assign tick_d = sec_end;

  trim_divider #(.LO_BITS(LO_BITS), .HI_COUNT(HI_COUNT)) i_div (
    .clk(clk), .rst_n(rst_sync_n), .adv(adv), .mode(mode), .sec_end(sec_end));

  trim_schedule #(.SEC_PER_MIN(SEC_PER_MIN), .CAL_BITS(CAL_BITS)) i_sched (
    .clk(clk), .rst_n(rst_sync_n), .sec_end(sec_end), .cal_mag(cal_mag),
    .cal_sign(cal_sign), .mode(mode));

  ftest_out #(.FT_BITS(FT_BITS)) i_ft (
    .clk(clk), .rst_n(rst_sync_n), .adv(adv), .ftest_en(ftest_en),
    .out_level(out_level), .pin(ftest_pin));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sec_tick <= 1'b0;
    else             sec_tick <= tick_d;
  end

  AST_TICK_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sec_tick |-> $past(osc_en && !halt)); // R2
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sec_tick |=> !sec_tick); // R2
endmodule

// File: tb/test_rtc_trim_prescaler.sv
module test_rtc_trim_prescaler;
  localparam int LO   = 2;
  localparam int HI   = 4;
  localparam int SPM  = 3;
  localparam int FTB  = 2;
  localparam int CYC  = 64;
  localparam int BASE = HI * (1 << LO);
  localparam int NSEC = CYC * SPM + 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0, halt = 1'b0;
  logic [4:0] cal_mag = '0;
  logic       cal_sign = 1'b0, ftest_en = 1'b0, out_level = 1'b0;
  logic       sec_tick, ftest_pin;

  int  checks = 0, failures = 0;
  int  cnt = 0, k = 0, ftcnt = 0;
  bit  prev_adv = 0, meas_on = 0, last_pin = 0, done = 0;
  int  wd = 0;

  always #2 clk = ~clk;

  rtc_trim_prescaler #(.LO_BITS(LO), .HI_COUNT(HI), .SEC_PER_MIN(SPM),
                       .CAL_BITS(5), .FT_BITS(FTB)) i_rtc_trim_prescaler (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .halt(halt), .cal_mag(cal_mag),
    .cal_sign(cal_sign), .ftest_en(ftest_en), .out_level(out_level),
    .sec_tick(sec_tick), .ftest_pin(ftest_pin));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int idx);
    int s = idx % SPM;
    int m = (idx / SPM) % CYC;
    if (s == 0 && m < 2 * cal_mag)
      return cal_sign ? BASE - (1 << LO) : BASE + (1 << (LO - 1));
    return BASE;
  endfunction

  // measurement on the falling edge
  always @(negedge clk) begin
    if (!meas_on) begin
      cnt = 0; k = 0; ftcnt = 0; prev_adv = 0; last_pin = ftest_pin;
    end else begin
      cnt   += int'(prev_adv);
      ftcnt += int'(prev_adv);
      if (sec_tick) begin
        if (exp_len(k) == BASE)
          chk(cnt == exp_len(k), "R1/R5 nominal second", cnt, exp_len(k));
        else if (cal_sign)
          chk(cnt == exp_len(k), "R3/R5 shortened second", cnt, exp_len(k));
        else
          chk(cnt == exp_len(k), "R4/R5 lengthened second", cnt, exp_len(k));
        if (!ftest_en)
          chk(ftest_pin == out_level, "R8 static pin", ftest_pin, out_level);
        k++;
        cnt = 0;
      end
      if (ftest_en && ftest_pin != last_pin) begin
        chk(ftcnt == (1 << FTB), "R7 test toggle interval", ftcnt, 1 << FTB);
        ftcnt = 0;
      end
      last_pin = ftest_pin;
      prev_adv = osc_en && !halt;
    end
  end

  task automatic do_reset(input bit fte, input bit lvl);
    meas_on = 0; osc_en = 0; halt = 0; ftest_en = fte; out_level = lvl;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sec_tick == 1'b0, "R10 reset tick", sec_tick, 0);
    chk(ftest_pin == (fte ? 1'b0 : lvl), "R10 reset pin", ftest_pin, fte ? 0 : lvl);
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    meas_on = 1; osc_en = 1;
  endtask

  task automatic sweep(input int mag, input bit sgn, input bit fte, input bit lvl);
    cal_mag = 5'(mag); cal_sign = sgn;
    do_reset(fte, lvl);
    wait (k == NSEC);
    @(posedge clk);
    #1;
    // R6 second NSEC-6 is minute 0 again after the wrap
    chk(k == NSEC, "R6 seconds completed past wrap", k, NSEC);
  endtask

  initial begin
    bit held;
    int mags[7] = '{0, 1, 2, 6, 15, 30, 31};
    foreach (mags[i]) begin
      sweep(mags[i], 1'b0, 1'b0, 1'(i % 2));
      sweep(mags[i], 1'b1, 1'b1, 1'b0);
    end
    // R9: halt and oscillator gaps freeze everything
    cal_mag = 5'd0; cal_sign = 1'b0;
    do_reset(1'b1, 1'b0);
    repeat (7) @(posedge clk);
    #1 halt = 1;
    @(negedge clk);
    held = ftest_pin;
    repeat (20) begin
      @(negedge clk);
      chk(sec_tick == 1'b0, "R9 no tick in halt", sec_tick, 0);
      chk(ftest_pin == held, "R9 pin held in halt", ftest_pin, held);
    end
    @(posedge clk); #1 halt = 0;
    repeat (3) @(posedge clk);
    #1 osc_en = 0;
    repeat (15) begin
      @(negedge clk);
      chk(sec_tick == 1'b0, "R9 no tick without osc", sec_tick, 0);
    end
    @(posedge clk); #1 osc_en = 1;
    wait (k == 2);
    @(posedge clk); #1;
    chk(k == 2, "R9 seconds after resume", k, 2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule